// File: doc/BRIEF.md
# Serial Output-Enable Control Port

This block gives a multi-output clock buffer a small serial port for switching its outputs on and off one by one. A controller drives three wires: a load strobe, a serial data line and a serial clock. While the strobe is high, each serial clock rising edge moves one data bit into a staging shift register. When the strobe falls, the whole staging register is copied into a holding register, and that holding register drives the per-output enable vector. A fourth wire, the serial output, carries the last stage of the staging register. Several devices can therefore be chained end to end, or they can share the three input wires in a star arrangement.

The three serial wires are brought into the core clock domain through two-flop synchronizers, and the edges are detected after synchronization. The port has no power-state gating, so it keeps working while the device is held in power-down. Each output's final enable is the serial holding bit ANDed with the matching bit from the parallel (SMBus) control path, so both control paths stay in effect.

The output count is a parameter. A second parameter sets which end of the chain holds output 0.

Top module: `sideband_oe_port`

## Requirements
- R1: After reset, every holding register bit is 1, so all outputs are enabled when the matching parallel enable bits are 1. Every staging register bit is 0, so `serOut` reads 0.
- R2: While the synchronized load strobe is high, each synchronized rising edge of `serClk` shifts the synchronized `serData` bit into the stage nearest the serial input. Every other stage moves one place toward the serial output.
- R3: While the load strobe is low, `serClk` edges have no effect: `serOut` and the staging register keep their contents.
- R4: The holding register changes only on a falling edge of the load strobe. On that edge it takes the whole staging register at once. Shifting does not disturb the enables already in use.
- R5: `serOut` always presents the stage nearest the serial output. A bit shifted in therefore reappears on `serOut` after `NUM_OUT` further shifts, which allows daisy chaining.
- R6: With `CHAIN_ASCEND` = 0 (used for 4- and 8-output builds), output 0 is the stage nearest `serOut`, and the highest-numbered output is the stage nearest `serData`. Output 0's bit is shifted first.
- R7: With `CHAIN_ASCEND` = 1 (used for the 20-output build), output 0 is the stage nearest `serData`, and the highest-numbered output is the stage nearest `serOut`. The highest-numbered output's bit is shifted first.
- R8: `outEnable[i]` is 1 only when holding bit i and `smbusEn[i]` are both 1.
- R9: After the load strobe's falling edge is driven, `outEnable` changes on the third rising core clock edge and not before. `serClk` must run at no more than a quarter of the core clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStrobe | input | 1 | High: shifting allowed. Falling edge: transfer to the holding register |
| serData | input | 1 | Serial data input |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| smbusEn | input | NUM_OUT | Per-output enables from the parallel control path |
| serOut | output | 1 | Last staging stage, used for chaining |
| outEnable | output | NUM_OUT | Final per-output enable |

## Verification
The assertions assume that `serClk`, `loadStrobe` and `serData` are slow compared with the core clock. Each level must be held for several core cycles, so that the synchronizers see every edge and the data is stable when the clock edge is sampled. The stimulus changes these wires only on falling core clock edges. It holds each level for four core cycles, sets the data before raising `serClk`, and waits before moving the strobe. Each shift and each load is then seen exactly once after synchronization. The parallel enables are treated as static inputs and changed only between serial transactions.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // Strobes passed from the control logic to the datapath
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } ctlStrobes_t;
endpackage

// File: rtl/sbc_ctl.sv
module sbc_ctl
  import sbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadStrobe,
  input  logic        serClk,
  input  logic        serData,
  output ctlStrobes_t strobes,
  output logic        dataBit
);
  localparam int HIST = SYNC_STAGES + 1;

  logic [HIST-1:0]        clkPipe;
  logic [HIST-1:0]        ldPipe;
  logic [SYNC_STAGES-1:0] datPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      ldPipe  <= '0;
      datPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[HIST-2:0], serClk};
      ldPipe  <= {ldPipe[HIST-2:0], loadStrobe};
      datPipe <= {datPipe[SYNC_STAGES-2:0], serData};
    end
  end

  logic clkNow, clkOld, ldNow, ldOld;
  assign clkNow = clkPipe[SYNC_STAGES-1];
  assign clkOld = clkPipe[SYNC_STAGES];
  assign ldNow  = ldPipe[SYNC_STAGES-1];
  assign ldOld  = ldPipe[SYNC_STAGES];

  always_comb begin
    strobes.shiftEn = clkNow & ~clkOld & ldNow;
    strobes.loadEn  = ~ldNow & ldOld;
  end

  assign dataBit = datPipe[SYNC_STAGES-1];
endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int NUM_OUT      = 8,
  parameter bit CHAIN_ASCEND = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic               dataBit,
  input  logic [NUM_OUT-1:0] smbusEn,
  output logic [NUM_OUT-1:0] shiftReg,
  output logic [NUM_OUT-1:0] holdReg,
  output logic               serOut,
  output logic [NUM_OUT-1:0] outEnable
);
  localparam int LAST = NUM_OUT - 1;

  // Stage 0 sits at the serial input, stage LAST at the serial output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[LAST-1:0], dataBit};
  end

  logic [NUM_OUT-1:0] mapped;
  generate
    if (CHAIN_ASCEND) begin : g_asc
      assign mapped = shiftReg;
    end else begin : g_desc
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
        assign mapped[i] = shiftReg[LAST-i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdReg <= '1;
    else if (strobes.loadEn) holdReg <= mapped;
  end

  assign serOut    = shiftReg[LAST];
  assign outEnable = holdReg & smbusEn;
endmodule

// File: rtl/sideband_oe_port.sv
module sideband_oe_port
  import sbc_pkg::*;
#(
  parameter int NUM_OUT      = 8,
  parameter bit CHAIN_ASCEND = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadStrobe,
  input  logic               serData,
  input  logic               serClk,
  input  logic [NUM_OUT-1:0] smbusEn,
  output logic               serOut,
  output logic [NUM_OUT-1:0] outEnable
);
  ctlStrobes_t        strobes;
  logic               dataBit;
  logic [NUM_OUT-1:0] shiftReg;
  logic [NUM_OUT-1:0] holdReg;

  sbc_ctl #(.SYNC_STAGES(2)) u_ctl (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .serClk(serClk),
    .serData(serData), .strobes(strobes), .dataBit(dataBit)
  );

  sbc_datapath #(.NUM_OUT(NUM_OUT), .CHAIN_ASCEND(CHAIN_ASCEND)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataBit(dataBit),
    .smbusEn(smbusEn), .shiftReg(shiftReg), .holdReg(holdReg),
    .serOut(serOut), .outEnable(outEnable)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int NUM_OUT = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               shiftEn,
  input logic               loadEn,
  input logic               dataBit,
  input logic [NUM_OUT-1:0] shiftReg,
  input logic [NUM_OUT-1:0] holdReg,
  input logic               serOut,
  input logic [NUM_OUT-1:0] smbusEn,
  input logic [NUM_OUT-1:0] outEnable
);
  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> shiftReg[0] == $past(dataBit));
  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> $stable(shiftReg));
  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadEn |=> $stable(holdReg));
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftEn && loadEn));
  // R5
  chain_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> serOut == $past(shiftReg[NUM_OUT-2]));
  // R8
  and_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEnable & ~smbusEn) == '0);
endmodule

bind sideband_oe_port sbc_checker #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .shiftEn(strobes.shiftEn), .loadEn(strobes.loadEn),
  .dataBit(dataBit), .shiftReg(shiftReg), .holdReg(holdReg), .serOut(serOut),
  .smbusEn(smbusEn), .outEnable(outEnable)
);

// File: tb/test_sideband_oe_port.sv
module test_sideband_oe_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  // Instance A: 8 outputs, descending chain
  logic ldA = 0, sdA = 0, scA = 0, soA;
  logic [7:0] smA = 8'hFF, oeA;
  // Instance B: 4 outputs, ascending chain
  logic ldB = 0, sdB = 0, scB = 0, soB;
  logic [3:0] smB = 4'hF, oeB;

  sideband_oe_port #(.NUM_OUT(8), .CHAIN_ASCEND(1'b0)) i_sideband_oe_port (
    .clk(clk), .rstN(rstN), .loadStrobe(ldA), .serData(sdA), .serClk(scA),
    .smbusEn(smA), .serOut(soA), .outEnable(oeA));
  sideband_oe_port #(.NUM_OUT(4), .CHAIN_ASCEND(1'b1)) i_sideband_oe_portAsc (
    .clk(clk), .rstN(rstN), .loadStrobe(ldB), .serData(sdB), .serClk(scB),
    .smbusEn(smB), .serOut(soB), .outEnable(oeB));

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseA(input logic b);
    sdA = b; waitCyc(4); scA = 1; waitCyc(4); scA = 0;
  endtask

  task automatic pulseB(input logic b);
    sdB = b; waitCyc(4); scB = 1; waitCyc(4); scB = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] prevA;
    logic [3:0] prevB;
    waitCyc(3);
    rstN = 1;
    waitCyc(2);
    // R1 reset state
    check("R1 enables A", oeA, 8'hFF);
    check("R1 enables B", oeB, 4'hF);
    check("R1 serOut A", soA, 0);
    check("R1 serOut B", soB, 0);

    prevA = 8'h00; // staging content before first pattern
    for (int p = 0; p < 256; p++) begin
      logic [7:0] pat;
      logic [7:0] held;
      pat = p[7:0];
      held = (p == 0) ? 8'hFF : prevA;
      ldA = 1; waitCyc(4);
      for (int k = 0; k < 8; k++) begin
        // R5 previous word emerges in order
        check("R5 chain out A", soA, prevA[k]);
        if (k == 4) check("R4 hold during shift", oeA, held);
        pulseA(pat[k]);
      end
      waitCyc(4);
      ldA = 0;
      @(posedge clk); @(posedge clk); #1;
      check("R9 not yet loaded", oeA, held);
      @(posedge clk); #1;
      check("R9 loaded on third edge", oeA, pat);
      waitCyc(3);
      // R2 R6 mapping with descending order
      check("R6 descending map", oeA, pat);
      prevA = pat;
      if (p % 16 == 5) begin
        // R3 clocks with strobe low are ignored
        for (int k = 0; k < 8; k++) pulseA(~pat[k]);
        waitCyc(4);
        check("R3 serOut unchanged", soA, pat[0]);
        check("R3 enables unchanged", oeA, pat);
        ldA = 1; waitCyc(6); ldA = 0; waitCyc(6);
        check("R3 staging unchanged", oeA, pat);
      end
    end

    // R8 AND with parallel enables
    for (int m = 0; m < 256; m++) begin
      smA = m[7:0];
      waitCyc(1);
      check("R8 and mask", oeA, prevA & m[7:0]);
    end
    smA = 8'hFF;

    prevB = 4'h0;
    for (int p = 0; p < 16; p++) begin
      logic [3:0] pat;
      pat = p[3:0];
      ldB = 1; waitCyc(4);
      for (int k = 0; k < 4; k++) begin
        check("R5 chain out B", soB, prevB[3-k]);
        pulseB(pat[3-k]);
      end
      waitCyc(4);
      ldB = 0;
      waitCyc(6);
      check("R7 ascending map", oeB, pat);
      prevB = pat;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule